// File: doc/BRIEF.md
# Accumulate-Mode Hash Padding Detector

This block sits in front of a hash core that is fed one message in several requests. Software hands over the message piece by piece and appends the standard Merkle–Damgård padding to the last piece itself, with no flag saying which piece is last. For every accumulate request the block adds the request length to a running byte total. It then reads the trailing eight bytes of the request buffer through a byte-read port and treats them as the big-endian bit count of the whole message. It works out where the padding would have to start and checks that the byte there is the 0x80 padding marker.

When the check succeeds, the request is the final one. The block reports how many leading bytes are real payload, raises a final flag, and clears its running total so the next message starts from zero. When the check fails, the whole request counts as payload and the total is kept. A request that is not in accumulate mode stands alone: it never counts as final, and it clears the total. Each request is accepted with a valid/ready pair and answered with a one-cycle `done` pulse. The read port has one cycle of latency: the byte for an address presented with `rd_en` must be on `rd_data` during the next cycle.

Top module: `hash_pad_detect`

## Requirements
- R1: An accepted accumulate request (`req_acc`=1) adds `req_len` to the running total, and the padding check uses the total that already includes that request.
- R2: The length field is the eight bytes at request offsets `req_len-8` to `req_len-1`. They are read in that order, and the first byte read is the most significant byte of a 64-bit bit count. The bit count divided by 8 (shifted right by 3) is the message byte length. If any bit count bit above the running-total width plus 3 is set, the request is not final.
- R3: A request is a padding candidate only if the message length is at most the running total and the padding size (total minus message length) is between 1 and `req_len` inclusive. Otherwise the result is non-final after exactly 8 reads.
- R4: For a candidate, a ninth read fetches the byte at offset `req_len` minus the padding size. The request is final only if that byte equals 0x80.
- R5: A final result gives `res_final`=1, `payload_len` = `req_len` minus the padding size, and `total_clr`=1, and it returns the running total to zero.
- R6: Every non-final result gives `res_final`=0 and `payload_len` = `req_len`.
- R7: An accumulate request shorter than 8 bytes makes no reads. It is answered non-final in the cycle after acceptance, and its length is still added to the total.
- R8: A non-accumulate request makes no reads. It is answered in the cycle after acceptance with `res_final`=0, `payload_len` = `req_len` and `total_clr`=1, and the running total becomes zero.
- R9: Reset (`rst_n` low) sets the running total to zero and leaves `req_ready`=1, `done`=0 and `rd_en`=0.
- R10: `req_ready` is high only while the block is idle. It drops in the cycle after an accepted request that needs reads, and every result is a `done` pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_len | input | LEN_W | Request length in bytes |
| req_acc | input | 1 | Request belongs to an accumulate-mode message |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | LEN_W | Byte offset within the current request buffer |
| rd_data | input | 8 | Byte returned one cycle after `rd_en` |
| done | output | 1 | Result valid, one-cycle pulse |
| res_final | output | 1 | Request carried the padding and ends the message |
| payload_len | output | LEN_W | Bytes to pass to the hash core |
| total_clr | output | 1 | Running total was cleared by this result |

## Verification
The bench builds the block with its defaults: a 16-bit request length and a 32-bit running total. With a 32-bit total, a bit count that has its top bit set lies outside the usable width, so the out-of-range rejection of R2 can be reached with a single vector. The 16-bit length lets requests of 5 to 64 bytes drive the padding size across every boundary: zero, exactly equal to the request, and larger than the request. A vector sequence shows the total carrying across several non-final requests. It also shows the total being cleared by a final request, by a standalone request and by reset.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
   localparam int FIELD_BYTES = 8;
   localparam logic [7:0] PAD_MARKER = 8'h80;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DRAIN,
      ST_EVAL,
      ST_MARK
   } hpd_state_t;
endpackage

// File: rtl/hpd_accum.sv
module hpd_accum #(
   parameter int LEN_W = 16,
   parameter int TOT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [LEN_W-1:0] add_len,
   input  logic             clr,
   output logic [TOT_W-1:0] total
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      total <= '0;
      else if (clr)    total <= '0;
      else if (add_en) total <= total + TOT_W'(add_len);
   end

   a_r1_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      add_en && !clr |=> total == $past(total) + TOT_W'($past(add_len)));

   a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> total == '0);
endmodule

// File: rtl/hpd_fetch.sv
module hpd_fetch #(
   parameter int NBYTES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  cap,
   input  logic [7:0]            rd_data,
   output logic [NBYTES*8-1:0]   field
);
   localparam int FW = NBYTES * 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     field <= '0;
      else if (start) field <= '0;
      else if (cap)   field <= {field[FW-9:0], rd_data};
   end

   a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      cap && !start |=> field[7:0] == $past(rd_data) &&
                        field[FW-1:8] == $past(field[FW-9:0]));
endmodule

// File: rtl/hpd_judge.sv
module hpd_judge #(
   parameter int LEN_W = 16,
   parameter int TOT_W = 32
) (
   input  logic [TOT_W-1:0] total,
   input  logic [LEN_W-1:0] len,
   input  logic [63:0]      field,
   output logic             cand_ok,
   output logic [LEN_W-1:0] pad_off
);
   logic             ovf;
   logic [TOT_W-1:0] msg_len;
   logic [TOT_W-1:0] pad_sz;

   assign msg_len = field[TOT_W+2:3];

   if (TOT_W + 3 < 64) begin : g_ovf
      assign ovf = |field[63:TOT_W+3];
   end else begin : g_noovf
      assign ovf = 1'b0;
   end

   always_comb begin
      pad_sz  = total - msg_len;
      cand_ok = !ovf && (msg_len <= total) && (pad_sz != '0) &&
                (pad_sz <= TOT_W'(len));
      pad_off = len - pad_sz[LEN_W-1:0];
   end
endmodule

// File: rtl/hash_pad_detect.sv
module hash_pad_detect
   import hpd_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int TOT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_acc,
   output logic             rd_en,
   output logic [LEN_W-1:0] rd_addr,
   input  logic [7:0]       rd_data,
   output logic             done,
   output logic             res_final,
   output logic [LEN_W-1:0] payload_len,
   output logic             total_clr
);
   localparam int CW = $clog2(FIELD_BYTES);
   localparam logic [CW-1:0] CNT_LAST = CW'(FIELD_BYTES - 1);

   if (LEN_W < 4 || LEN_W > TOT_W || TOT_W > 61) begin : g_bad_cfg
      $error("hash_pad_detect: need 4 <= LEN_W <= TOT_W <= 61");
   end

   hpd_state_t       st;
   logic [LEN_W-1:0] len_q;
   logic [CW-1:0]    cnt;
   logic             len_pend;
   logic [63:0]      field;
   logic [TOT_W-1:0] total;
   logic             cand_ok;
   logic [LEN_W-1:0] pad_off;
   logic             accept;
   logic             hit;
   logic             acc_clr;

   assign req_ready = (st == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign hit       = (st == ST_MARK) && (rd_data == PAD_MARKER);
   assign acc_clr   = (accept && !req_acc) || hit;

   always_comb begin
      rd_en   = 1'b0;
      rd_addr = pad_off;
      if (st == ST_FETCH) begin
         rd_en   = 1'b1;
         rd_addr = len_q - LEN_W'(FIELD_BYTES) + LEN_W'(cnt);
      end else if (st == ST_EVAL && cand_ok) begin
         rd_en   = 1'b1;
      end
   end

   hpd_accum #(.LEN_W(LEN_W), .TOT_W(TOT_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (accept && req_acc),
      .add_len (req_len),
      .clr     (acc_clr),
      .total   (total)
   );

   hpd_fetch #(.NBYTES(FIELD_BYTES)) u_fetch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .cap     (len_pend),
      .rd_data (rd_data),
      .field   (field)
   );

   hpd_judge #(.LEN_W(LEN_W), .TOT_W(TOT_W)) u_judge (
      .total   (total),
      .len     (len_q),
      .field   (field),
      .cand_ok (cand_ok),
      .pad_off (pad_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         len_q       <= '0;
         cnt         <= '0;
         len_pend    <= 1'b0;
         done        <= 1'b0;
         res_final   <= 1'b0;
         payload_len <= '0;
         total_clr   <= 1'b0;
      end else begin
         done      <= 1'b0;
         res_final <= 1'b0;
         total_clr <= 1'b0;
         len_pend  <= (st == ST_FETCH);
         unique case (st)
            ST_IDLE: if (accept) begin
               len_q <= req_len;
               cnt   <= '0;
               if (!req_acc || req_len < LEN_W'(FIELD_BYTES)) begin
                  done        <= 1'b1;
                  payload_len <= req_len;
                  total_clr   <= !req_acc;
               end else begin
                  st <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_LAST) st <= ST_DRAIN;
            end
            ST_DRAIN: st <= ST_EVAL;
            ST_EVAL: begin
               if (cand_ok) begin
                  st <= ST_MARK;
               end else begin
                  st          <= ST_IDLE;
                  done        <= 1'b1;
                  payload_len <= len_q;
               end
            end
            ST_MARK: begin
               st          <= ST_IDLE;
               done        <= 1'b1;
               res_final   <= hit;
               total_clr   <= hit;
               payload_len <= hit ? pad_off : len_q;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !req_ready);

   a_r5_final_result: assert property (@(posedge clk) disable iff (!rst_n)
      done && res_final |-> total_clr && (payload_len < len_q));

   a_r6_nonfinal_payload: assert property (@(posedge clk) disable iff (!rst_n)
      done && !res_final |-> payload_len == len_q);

   a_r7_short_request: assert property (@(posedge clk) disable iff (!rst_n)
      accept && req_acc && (req_len < LEN_W'(FIELD_BYTES)) |=>
         done && !res_final && !total_clr);

   a_r8_standalone: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !req_acc |=> done && total_clr && !res_final && !rd_en);
endmodule

// File: tb/hash_pad_detect_tb.sv
module hash_pad_detect_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 16;
   localparam logic [15:0] NOMK = 16'hFFFF;

   typedef struct packed {
      logic [15:0] len;
      logic        acc;
      logic [63:0] fld;
      logic [15:0] mk;
      logic        fin;
      logic [15:0] pay;
      logic        clr;
      logic [3:0]  rds;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{16'd64, 1'b1, 64'd0,   NOMK,  1'b0, 16'd64, 1'b0, 4'd9},
      '{16'd32, 1'b1, 64'd640, 16'd16, 1'b1, 16'd16, 1'b1, 4'd9},
      '{16'd40, 1'b1, 64'd160, 16'd20, 1'b1, 16'd20, 1'b1, 4'd9},
      '{16'd48, 1'b1, 64'd400, NOMK,  1'b0, 16'd48, 1'b0, 4'd8},
      '{16'd16, 1'b1, 64'd480, 16'd4,  1'b0, 16'd16, 1'b0, 4'd9},
      '{16'd16, 1'b1, 64'd320, 16'd0,  1'b0, 16'd16, 1'b0, 4'd8},
      '{16'd24, 1'b0, 64'd64,  16'd8,  1'b0, 16'd24, 1'b1, 4'd0},
      '{16'd24, 1'b1, 64'd64,  16'd8,  1'b1, 16'd8,  1'b1, 4'd9},
      '{16'd5,  1'b1, 64'd0,   NOMK,  1'b0, 16'd5,  1'b0, 4'd0},
      '{16'd16, 1'b1, 64'd168, 16'd0,  1'b0, 16'd16, 1'b0, 4'd8},
      '{16'd32, 1'b1, 64'h8000_0000_0000_00B8, 16'd2, 1'b0, 16'd32, 1'b0, 4'd8},
      '{16'd16, 1'b1, 64'd480, 16'd7,  1'b1, 16'd7,  1'b1, 4'd9}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [LW-1:0] req_len = '0;
   logic          req_acc = 1'b0;
   logic          rd_en;
   logic [LW-1:0] rd_addr;
   logic [7:0]    rd_data = 8'h00;
   logic          done;
   logic          res_final;
   logic [LW-1:0] payload_len;
   logic          total_clr;

   logic [7:0] mem [256];
   int unsigned rd_count = 0;
   int unsigned cycles = 0;
   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rd_en) begin
         rd_data  <= mem[rd_addr[7:0]];
         rd_count <= rd_count + 1;
      end
   end

   hash_pad_detect #(.LEN_W(LW), .TOT_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_len(req_len), .req_acc(req_acc), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .done(done), .res_final(res_final),
      .payload_len(payload_len), .total_clr(total_clr)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic fill(input vec_t v);
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      if (v.len >= 8)
         for (int b = 0; b < 8; b++) mem[v.len - 8 + b] = v.fld[63-8*b -: 8];
      if (v.mk != NOMK) mem[v.mk] = 8'h80;
   endtask

   task automatic run(input vec_t v, input string tag);
      int unsigned r0;
      int wait_n;
      fill(v);
      @(negedge clk);
      r0 = rd_count;
      req_len = v.len; req_acc = v.acc; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (v.rds != 0) check("R10", {tag, " ready while busy"}, req_ready, 0);
      wait_n = 0;
      while (!done && wait_n < 40) begin
         @(negedge clk);
         wait_n++;
      end
      check(tag, "done seen", done, 1);
      check(v.fin ? "R5" : "R6", {tag, " final"}, res_final, v.fin);
      check(v.fin ? "R5" : "R6", {tag, " payload"}, payload_len, v.pay);
      check(v.acc ? "R5" : "R8", {tag, " total_clr"}, total_clr, v.clr);
      check(v.rds == 9 ? "R4" : (v.rds == 8 ? "R3" : "R7"), {tag, " reads"},
            rd_count - r0, v.rds);
      @(negedge clk);
      check("R10", {tag, " done one cycle"}, done, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      check("R9", "reset ready", req_ready, 1);
      check("R9", "reset done", done, 0);
      check("R9", "reset rd_en", rd_en, 0);
      rst_n = 1'b1;
      // R1 R2 R3 R4 R5 R6 R7 R8: vector walk, total carried between entries
      for (int k = 0; k < 12; k++) run(VECS[k], $sformatf("vec%0d", k));
      // R9: reset mid-message drops the accumulated total
      run('{16'd40, 1'b1, 64'd0, NOMK, 1'b0, 16'd40, 1'b0, 4'd9}, "R9 pre");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R9", "mid reset ready", req_ready, 1);
      check("R9", "mid reset rd_en", rd_en, 0);
      rst_n = 1'b1;
      run('{16'd24, 1'b1, 64'd64, 16'd8, 1'b1, 16'd8, 1'b1, 4'd9}, "R9 post");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule